// File: doc/BRIEF.md
# DRAM Self-Refresh Entry and Exit Sequencer

This block moves a DRAM into its low-power self-refresh mode and brings it back out. The memory controller raises `sleep_req` while the device is in normal operation. The sequencer then drives clock enable low and issues a single refresh-type command in that same cycle. This puts the device into self refresh. While the device sleeps, only clock enable matters to it. The sequencer holds clock enable low and drives no-operation on the command lines.

When `wake_req` arrives, the sequencer first waits for `clk_stable`. It then raises clock enable and issues no-operation commands for a fixed window. The window length is the larger of two parameters: the time the internal refresh needs to finish (`T_XSNR`), and the time the delay-locked loop needs to relock before a read (`T_DLL`, 200 cycles by default). After the window the sequencer reports `ready`, and normal reads may resume. A wake request that arrives during the entry cycle is kept and acted on once the device is asleep.

The states are:
- IDLE: normal operation, the state after reset.
- ENTER: one cycle, refresh command with clock enable low.
- IN_SELF_REFRESH: the device sleeps.
- WAIT_CLOCK: waiting for a stable clock.
- EXIT_NOP: the no-operation window.
- READY: one cycle that reports completion.

The transitions are:
- IDLE→ENTER and READY→ENTER on `sleep_req`.
- ENTER→IN_SELF_REFRESH always.
- IN_SELF_REFRESH→WAIT_CLOCK on `wake_req` or a held wake.
- WAIT_CLOCK→EXIT_NOP on `clk_stable`.
- EXIT_NOP→READY when the window has elapsed.
- READY→IDLE otherwise.

Top module: `dram_lowpower_seq`

## Requirements
- R1: After reset the outputs are `cke`=1, `cmd`=3'b111 (no-operation, as {ras_n,cas_n,we_n}) and `ready`=1.
- R2: A `sleep_req` seen in normal operation causes the next cycle to show `cke`=0 with `cmd`=3'b001 (refresh) and `ready`=0.
- R3: While asleep, `cke` stays 0, `cmd` is 3'b111 and `ready` is 0, and `sleep_req` has no effect.
- R4: A `wake_req` in normal operation has no effect, including one that coincides with `sleep_req`. The device then stays asleep until a later wake request.
- R5: `cke` rises only in the cycle after one in which `clk_stable` was 1. Until then, `cke` stays 0.
- R6: From the cycle in which `cke` rises, `cmd` is 3'b111 and `ready` is 0 for exactly max(`T_XSNR`,`T_DLL`) cycles.
- R7: In the cycle after that window, `ready` is 1 with `cke`=1 and `cmd`=3'b111.
- R8: A `wake_req` given during the refresh entry cycle is held. After one asleep cycle the exit proceeds without a further request.
- R9: The refresh command appears for exactly one cycle per entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Request to enter self refresh |
| wake_req | input | 1 | Request to leave self refresh |
| clk_stable | input | 1 | Memory clock is stable |
| cke | output | 1 | Clock enable to the DRAM |
| cmd | output | 3 | Command {ras_n,cas_n,we_n} |
| ready | output | 1 | Normal reads may be issued |

## Verification
Entry and wake can fall in the same cycle in two ways. In the first, a wake request lands exactly in the cycle that carries the refresh command. The scoreboard then expects one asleep cycle, one clock-wait cycle and the full no-operation window, with no second request. In the second, sleep and wake are raised together in normal operation. The scoreboard expects entry to win and the device to stay asleep with no exit.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER,
        ST_IN_SR,
        ST_WAIT_CLK,
        ST_EXIT_NOP,
        ST_READY
    } lp_state_e;

    // {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        CMD_NOP = 3'b111,
        CMD_REF = 3'b001
    } lp_cmd_e;

endpackage

// File: rtl/lp_exit_timer.sv
module lp_exit_timer #(
    parameter int WINDOW = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CW = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] START = CW'(WINDOW - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= START;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/lp_wake_hold.sv
module lp_wake_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
        end else if (clr_i) begin
            pend_o <= 1'b0;
        end else if (set_i) begin
            pend_o <= 1'b1;
        end
    end
endmodule

// File: rtl/dram_lowpower_seq.sv
module dram_lowpower_seq
    import lp_seq_pkg::*;
#(
    parameter int T_XSNR = 10,
    parameter int T_DLL  = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       wake_req,
    input  logic       clk_stable,
    output logic       cke,
    output logic [2:0] cmd,
    output logic       ready
);
    localparam int EXIT_CYC = (T_XSNR > T_DLL) ? T_XSNR : T_DLL;

    lp_state_e state_q, state_d;
    logic      win_done;
    logic      wake_pend;
    logic      load_win;
    logic      leave_sr;
    lp_cmd_e   cmd_v;

    assign leave_sr = (state_q == ST_IN_SR) && (wake_req || wake_pend);
    assign load_win = (state_q == ST_WAIT_CLK) && clk_stable;

    lp_exit_timer #(.WINDOW(EXIT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_win),
        .done  (win_done)
    );

    lp_wake_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  ((state_q == ST_ENTER) && wake_req),
        .clr_i  (leave_sr),
        .pend_o (wake_pend)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (sleep_req) state_d = ST_ENTER;
            ST_ENTER:    state_d = ST_IN_SR;
            ST_IN_SR:    if (leave_sr) state_d = ST_WAIT_CLK;
            ST_WAIT_CLK: if (clk_stable) state_d = ST_EXIT_NOP;
            ST_EXIT_NOP: if (win_done) state_d = ST_READY;
            ST_READY:    state_d = sleep_req ? ST_ENTER : ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        cke   = 1'b1;
        cmd_v = CMD_NOP;
        ready = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_READY: ready = 1'b1;
            ST_ENTER: begin
                cke   = 1'b0;
                cmd_v = CMD_REF;
            end
            ST_IN_SR, ST_WAIT_CLK: cke = 1'b0;
            ST_EXIT_NOP: cke = 1'b1;
            default: ready = 1'b0;
        endcase
    end

    assign cmd = cmd_v;
endmodule

// File: rtl/lp_seq_chk.sv
module lp_seq_chk #(
    parameter int T_XSNR = 10,
    parameter int T_DLL  = 200
) (
    input logic       clk,
    input logic       rst_n,
    input logic       clk_stable,
    input logic       cke,
    input logic [2:0] cmd,
    input logic       ready
);
    localparam int EXIT_CYC = (T_XSNR > T_DLL) ? T_XSNR : T_DLL;

    logic [15:0] win_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (cke && !ready) begin
            win_cnt <= win_cnt + 1'b1;
        end else begin
            win_cnt <= '0;
        end
    end

    // R2
    ref_low_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'b001) |-> (!cke && !ready));

    // R9
    single_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'b001) |=> (cmd == 3'b111));

    // R3
    asleep_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> !ready);

    // R5
    stable_before_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> $past(clk_stable));

    // R6
    exit_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !ready) |-> (cmd == 3'b111));

    // R7
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (cke && win_cnt == 16'(EXIT_CYC)));
endmodule

bind dram_lowpower_seq lp_seq_chk #(.T_XSNR(T_XSNR), .T_DLL(T_DLL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_stable (clk_stable),
    .cke        (cke),
    .cmd        (cmd),
    .ready      (ready)
);

// File: tb/dram_lowpower_seq_tb.sv
module dram_lowpower_seq_tb;
    localparam int XSNR = 5;
    localparam int DLL  = 12;
    localparam int WIN  = 12;

    typedef struct packed {
        logic       cke;
        logic [2:0] cmd;
        logic       rdy;
    } exp_t;

    localparam exp_t RUN = '{cke: 1'b1, cmd: 3'b111, rdy: 1'b1};
    localparam exp_t ENT = '{cke: 1'b0, cmd: 3'b001, rdy: 1'b0};
    localparam exp_t SLP = '{cke: 1'b0, cmd: 3'b111, rdy: 1'b0};
    localparam exp_t XIT = '{cke: 1'b1, cmd: 3'b111, rdy: 1'b0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic       wake_req = 1'b0;
    logic       clk_stable = 1'b0;
    logic       cke;
    logic [2:0] cmd;
    logic       ready;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    dram_lowpower_seq #(.T_XSNR(XSNR), .T_DLL(DLL)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .wake_req   (wake_req),
        .clk_stable (clk_stable),
        .cke        (cke),
        .cmd        (cmd),
        .ready      (ready)
    );

    // Driver: set inputs for this cycle and queue the outputs expected in it.
    task automatic step(input logic s, input logic w, input logic c,
                        input exp_t e, input string tag);
        sleep_req  = s;
        wake_req   = w;
        clk_stable = c;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
    endtask

    // Monitor: compare at the falling edge.
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            exp_t  e;
            exp_t  a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = '{cke: cke, cmd: cmd, rdy: ready};
            n_chk++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s: got cke=%b cmd=%b ready=%b, expected cke=%b cmd=%b ready=%b",
                         t, a.cke, a.cmd, a.rdy, e.cke, e.cmd, e.rdy);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        step(0, 0, 0, RUN, "R1 reset state");
        step(0, 1, 1, RUN, "R4 wake while running");
        step(0, 0, 0, RUN, "R4 wake ignored");
        step(1, 0, 0, RUN, "R2 sleep requested");
        step(0, 0, 0, ENT, "R2 entry refresh");
        step(1, 0, 1, SLP, "R3 asleep, sleep ignored");
        for (int i = 0; i < 5; i++) step(0, 0, 1, SLP, "R9 no repeat refresh");
        step(0, 1, 0, SLP, "R5 wake without stable clock");
        for (int i = 0; i < 4; i++) step(0, 0, 0, SLP, "R5 cke held low");
        step(0, 0, 1, SLP, "R5 clock becomes stable");
        for (int i = 0; i < WIN; i++) step(0, 0, 1, XIT, "R6 exit nop window");
        step(0, 0, 1, RUN, "R7 ready after window");
        step(0, 0, 1, RUN, "R7 stays ready");
        // wake in the entry cycle
        step(1, 0, 1, RUN, "R8 sleep requested");
        step(0, 1, 1, ENT, "R8 wake during entry");
        step(0, 0, 1, SLP, "R8 asleep with held wake");
        step(0, 0, 1, SLP, "R8 clock wait");
        for (int i = 0; i < WIN; i++) step(0, 0, 1, XIT, "R8 exit window");
        step(0, 0, 1, RUN, "R8 ready");
        // sleep and wake together while running
        step(1, 1, 1, RUN, "R4 sleep and wake together");
        step(0, 0, 1, ENT, "R4 entry wins");
        for (int i = 0; i < 4; i++) step(0, 0, 1, SLP, "R4 wake dropped, stays asleep");
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule